// File: doc/BRIEF.md
# Password-Gated Memory Access Controller

This block sits between a serial-bus front end and an 8 KB nonvolatile array. It decides, for each request, whether the access may go ahead. A request carries an operation, a 16-bit byte address, a 64-bit candidate password and a 64-bit data word. One cycle later the block answers with exactly one of two pulses: a grant or a deny. The front end performs the actual array access only on a grant.

Reads need the stored read password and writes need the stored write password, but only inside a protected window. The window starts at address zero and its size is chosen by three bits of an 8-bit control register. The control register itself answers at the all-ones address and always needs a password.

A saturating counter records wrong passwords. Once it is full, nothing that needs a password is granted until reset. A write-protect pin together with a lock bit in the control register can freeze the register. A low-supply input blocks every request.

Top module: `pwgate_ctrl`

## Requirements
- R1: After reset, `grant_o` and `deny_o` are low, `ctl_reg_o` equals the `CTL_INIT` parameter (default 8'h00), and the stored read and write passwords equal `RD_PW_INIT` and `WR_PW_INIT`.
- R2: A read or write to an array address (below 8192) that lies outside the protected window is granted whatever password it carries.
- R3: The control register's bits 2..0 select the size of the protected window [0, size): 000 none, 001 64, 010 128, 011 256, 100 512, 101 2048, 110 4096, 111 the whole 8192-byte array.
- R4: Inside the window, a read (op 2'b00) is granted only with the read password and a write (op 2'b01) only with the write password; the other password does not open it.
- R5: Address 16'hFFFF addresses the control register. A read there needs the read password. A write needs the write password and, when granted, loads `req_data_i[7:0]`. The layout is bit 7 lock enable, bit 6 supply flag, bits 5..3 timer select, bits 2..0 window size.
- R6: While `wp_pin_i` is high and control bit 7 is set, a control-register write is denied and leaves the register unchanged, even with the correct password. If either one is low, the correct write password is enough.
- R7: Each wrong password on a password-checked request gives a deny and adds one to a tamper count. When the count reaches 8, every password-checked request is denied, even with a correct password. A correct password does not lower the count; only reset clears it. Requests that need no password are still granted.
- R8: While `low_supply_i` is high, every request is denied and changes no state, and control bit 6 is cleared.
- R9: Requests to addresses from 8192 through 16'hFFFE are denied, and no password is compared.
- R10: Op 2'b10 replaces the read password and op 2'b11 replaces the write password with `req_data_i`. Both need the current write password, and a wrong one counts as tamper.
- R11: Each request gives exactly one of `grant_o` or `deny_o`, high for the single cycle after the request cycle. With no request, both stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | 00 read, 01 write, 10 set read password, 11 set write password |
| req_addr_i | input | 16 | Byte address; 16'hFFFF is the control register |
| req_pw_i | input | 64 | Candidate password |
| req_data_i | input | 64 | New password, or control data in bits 7..0 |
| wp_pin_i | input | 1 | Write-protect pin level |
| low_supply_i | input | 1 | Low-supply indication, active high |
| grant_o | output | 1 | Request granted (one-cycle pulse) |
| deny_o | output | 1 | Request refused (one-cycle pulse) |
| ctl_reg_o | output | 8 | Control register contents |

## Verification
For every window-size code, the bench probes both sides of each window edge. An off-by-one or wrongly mapped size would either open the last protected byte or lock the first free one.

The tamper sequence uses seven wrong passwords, then a correct one, then one more wrong one. This catches a counter that clears on success or saturates one step early or late. It also checks that free addresses stay open after saturation.

The lock is tried with each of its two inputs high on its own and with both high together. Low supply is applied with the flag set, so a design that lets a request through or keeps the flag shows up. Password swaps check that the old value stops working and that the wrong key cannot make the swap.

// File: rtl/pwgate_pkg.sv
package pwgate_pkg;

    typedef enum logic [1:0] {
        OP_READ    = 2'b00,
        OP_WRITE   = 2'b01,
        OP_SET_RDPW = 2'b10,
        OP_SET_WRPW = 2'b11
    } gate_op_e;

    localparam int unsigned CTL_W      = 8;
    localparam int unsigned CTL_LOCK   = 7;
    localparam int unsigned CTL_FLAG   = 6;
    localparam int unsigned CTL_SIZE_LSB = 0;
    localparam int unsigned SIZE_W     = 3;

    typedef struct packed {
        logic             grant;
        logic             deny;
        logic [CTL_W-1:0] ctl;
    } gate_state_t;

endpackage

// File: rtl/pwgate_area_map.sv
module pwgate_area_map #(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned ARRAY_BYTES = 8192,
    parameter int unsigned BLOCK_MIN   = 64
) (
    input  logic [2:0]        size_sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              in_array_o,
    output logic              protected_o
);
    localparam int unsigned CODES = 8;

    logic [CODES-1:0] below_limit;

    // One comparator per size code; the selected one decides.
    for (genvar g = 0; g < CODES; g++) begin : g_limit
        if (g == 0) begin : g_none
            assign below_limit[g] = 1'b0;
        end else if (g == CODES - 1) begin : g_all
            assign below_limit[g] = (32'(addr_i) < ARRAY_BYTES);
        end else begin : g_part
            // codes above 4 skip one doubling step (512 -> 2048)
            localparam int unsigned SHIFT = g - 1 + ((g > 4) ? 1 : 0);
            localparam int unsigned LIMIT = BLOCK_MIN << SHIFT;
            assign below_limit[g] = (32'(addr_i) < LIMIT);
        end
    end

    assign in_array_o  = (32'(addr_i) < ARRAY_BYTES);
    assign protected_o = below_limit[size_sel_i];

endmodule

// File: rtl/pwgate_keys.sv
module pwgate_keys #(
    parameter int unsigned     PW_W    = 64,
    parameter logic [PW_W-1:0] RD_INIT = '0,
    parameter logic [PW_W-1:0] WR_INIT = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_rd_i,
    input  logic            load_wr_i,
    input  logic [PW_W-1:0] new_pw_i,
    input  logic [PW_W-1:0] cand_i,
    output logic            rd_match_o,
    output logic            wr_match_o
);
    logic [PW_W-1:0] rd_pw_d, rd_pw_q;
    logic [PW_W-1:0] wr_pw_d, wr_pw_q;

    always_comb begin
        rd_pw_d = rd_pw_q;
        wr_pw_d = wr_pw_q;
        if (load_rd_i) rd_pw_d = new_pw_i;
        if (load_wr_i) wr_pw_d = new_pw_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_pw_q <= RD_INIT;
            wr_pw_q <= WR_INIT;
        end else begin
            rd_pw_q <= rd_pw_d;
            wr_pw_q <= wr_pw_d;
        end
    end

    assign rd_match_o = (cand_i == rd_pw_q);
    assign wr_match_o = (cand_i == wr_pw_q);

    // R10: a key only moves when its load strobe was raised
    a_r10_rd_key_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load_rd_i |=> $stable(rd_pw_q));
    a_r10_wr_key_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load_wr_i |=> $stable(wr_pw_q));

endmodule

// File: rtl/pwgate_tamper.sv
module pwgate_tamper #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bump_i,
    output logic sat_o
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (bump_i && !sat_o) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign sat_o = (cnt_q == CNT_W'(LIMIT));

    // R7: count never exceeds the limit, never goes down, saturation sticks
    a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LIMIT));
    a_r7_never_down: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_q >= $past(cnt_q));
    a_r7_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |=> sat_o);

endmodule

// File: rtl/pwgate_ctrl.sv
module pwgate_ctrl
    import pwgate_pkg::*;
#(
    parameter int unsigned     ADDR_W       = 16,
    parameter int unsigned     ARRAY_BYTES  = 8192,
    parameter int unsigned     BLOCK_MIN    = 64,
    parameter int unsigned     PW_W         = 64,
    parameter int unsigned     TAMPER_LIMIT = 8,
    parameter logic [PW_W-1:0] RD_PW_INIT   = 64'h0123_4567_89AB_CDEF,
    parameter logic [PW_W-1:0] WR_PW_INIT   = 64'hFEDC_BA98_7654_3210,
    parameter logic [7:0]      CTL_INIT     = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [1:0]        req_op_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [PW_W-1:0]   req_pw_i,
    input  logic [PW_W-1:0]   req_data_i,
    input  logic              wp_pin_i,
    input  logic              low_supply_i,
    output logic              grant_o,
    output logic              deny_o,
    output logic [7:0]        ctl_reg_o
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = '1;

    gate_state_t st_d, st_q;
    gate_op_e    op;
    logic        is_ctl, in_array, in_window, mem_op;
    logic        need_pw, pw_ok, locked;
    logic        rd_match, wr_match, sat;
    logic        bump, load_rd, load_wr;

    assign op     = gate_op_e'(req_op_i);
    assign mem_op = (op == OP_READ) || (op == OP_WRITE);
    assign is_ctl = (req_addr_i == CTL_ADDR);

    pwgate_area_map #(
        .ADDR_W      (ADDR_W),
        .ARRAY_BYTES (ARRAY_BYTES),
        .BLOCK_MIN   (BLOCK_MIN)
    ) i_area (
        .size_sel_i  (st_q.ctl[CTL_SIZE_LSB +: SIZE_W]),
        .addr_i      (req_addr_i),
        .in_array_o  (in_array),
        .protected_o (in_window)
    );

    pwgate_keys #(
        .PW_W    (PW_W),
        .RD_INIT (RD_PW_INIT),
        .WR_INIT (WR_PW_INIT)
    ) i_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_rd_i  (load_rd),
        .load_wr_i  (load_wr),
        .new_pw_i   (req_data_i),
        .cand_i     (req_pw_i),
        .rd_match_o (rd_match),
        .wr_match_o (wr_match)
    );

    pwgate_tamper #(
        .LIMIT (TAMPER_LIMIT)
    ) i_tamper (
        .clk    (clk),
        .rst_n  (rst_n),
        .bump_i (bump),
        .sat_o  (sat)
    );

    // Which key applies and whether one is needed at all
    assign need_pw = !mem_op || is_ctl || in_window;
    assign pw_ok   = (op == OP_READ) ? rd_match : wr_match;
    assign locked  = (op == OP_WRITE) && is_ctl && wp_pin_i && st_q.ctl[CTL_LOCK];

    always_comb begin
        st_d       = st_q;
        st_d.grant = 1'b0;
        st_d.deny  = 1'b0;
        bump       = 1'b0;
        load_rd    = 1'b0;
        load_wr    = 1'b0;
        if (req_valid_i) begin
            if (low_supply_i) begin
                st_d.deny = 1'b1;
            end else if (mem_op && !is_ctl && !in_array) begin
                st_d.deny = 1'b1;
            end else if (locked) begin
                st_d.deny = 1'b1;
            end else if (!need_pw) begin
                st_d.grant = 1'b1;
            end else if (sat) begin
                st_d.deny = 1'b1;
            end else if (pw_ok) begin
                st_d.grant = 1'b1;
                if (op == OP_WRITE && is_ctl) st_d.ctl = req_data_i[CTL_W-1:0];
                load_rd = (op == OP_SET_RDPW);
                load_wr = (op == OP_SET_WRPW);
            end else begin
                st_d.deny = 1'b1;
                bump      = 1'b1;
            end
        end
        if (low_supply_i) st_d.ctl[CTL_FLAG] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.grant <= 1'b0;
            st_q.deny  <= 1'b0;
            st_q.ctl   <= CTL_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o   = st_q.grant;
    assign deny_o    = st_q.deny;
    assign ctl_reg_o = st_q.ctl;

    // R11: never both, and silence without a request
    a_r11_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_o, deny_o}));
    a_r11_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !grant_o && !deny_o);
    a_r11_answer_given: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> grant_o || deny_o);
    // R8: low supply blocks and clears the flag
    a_r8_low_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && low_supply_i |=> deny_o);
    a_r8_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        low_supply_i |=> !ctl_reg_o[CTL_FLAG]);
    // R6: hardware lock keeps the register
    a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && !low_supply_i && op == OP_WRITE && is_ctl
            && wp_pin_i && ctl_reg_o[CTL_LOCK] |=> deny_o && $stable(ctl_reg_o));
    // R9: gap addresses are refused
    a_r9_gap_denied: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && mem_op && !is_ctl && 32'(req_addr_i) >= ARRAY_BYTES |=> deny_o);
    // R4: a protected read without the read key is refused
    a_r4_read_key: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && op == OP_READ && in_window && !is_ctl && !rd_match |=> deny_o);
    // R7: saturation refuses password-checked requests
    a_r7_sat_denies: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && sat && need_pw |=> !grant_o);

endmodule

// File: tb/test_pwgate_ctrl.sv
`timescale 1ns/1ps
module test_pwgate_ctrl;

    localparam logic [63:0] RDPW   = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] WRPW   = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] BADPW  = 64'h0;
    localparam logic [63:0] NEW_RD = 64'h1111_2222_3333_4444;
    localparam logic [63:0] NEW_WR = 64'h5555_6666_7777_8888;
    localparam logic [15:0] CTLA   = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [15:0] addr = '0;
    logic [63:0] pw = '0;
    logic [63:0] data = '0;
    logic        wp = 1'b0;
    logic        low = 1'b0;
    logic        grant, deny;
    logic [7:0]  ctl;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pwgate_ctrl i_pwgate_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (valid),
        .req_op_i     (op),
        .req_addr_i   (addr),
        .req_pw_i     (pw),
        .req_data_i   (data),
        .wp_pin_i     (wp),
        .low_supply_i (low),
        .grant_o      (grant),
        .deny_o       (deny),
        .ctl_reg_o    (ctl)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic req(input logic [1:0] o, input logic [15:0] a, input logic [63:0] p,
                       input logic [63:0] d, input bit exp_g, input string tag);
        @(negedge clk);
        valid = 1'b1; op = o; addr = a; pw = p; data = d;
        @(negedge clk);
        check(grant == exp_g && deny == !exp_g, tag, {62'h0, grant, deny}, {62'h0, exp_g, !exp_g});
        valid = 1'b0;
    endtask

    task automatic set_ctl(input logic [7:0] v, input string tag);
        req(2'b01, CTLA, WRPW, {56'h0, v}, 1'b1, tag);
        check(ctl == v, tag, {56'h0, ctl}, {56'h0, v});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic int win_size(input int bl);
        if (bl == 0) return 0;
        if (bl == 7) return 8192;
        if (bl <= 4) return 32 << bl;
        return 64 << bl;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R11: watchdog expired, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!grant && !deny, "R1 outputs idle", {62'h0, grant, deny}, 64'h0);
        check(ctl == 8'h00, "R1 control init", {56'h0, ctl}, 64'h0);
        // R11 no request, no answer
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!grant && !deny, "R11 idle silent", {62'h0, grant, deny}, 64'h0);
        end
        // R1 initial keys work
        set_ctl(8'h07, "R1 write key from reset");
        req(2'b00, 16'd0, RDPW, 64'h0, 1'b1, "R1 read key from reset");

        // R2/R3 sweep of every window size across its edges
        for (int bl = 0; bl < 8; bl++) begin
            int sz;
            do_reset();
            set_ctl(8'(bl), "R5 size write");
            sz = win_size(bl);
            for (int k = 0; k < 4; k++) begin
                int a;
                bit skip;
                skip = 1'b0;
                case (k)
                    0: a = 0;
                    1: begin a = sz - 1; skip = (sz == 0); end
                    2: begin a = sz; skip = (sz >= 8192); end
                    default: a = 8191;
                endcase
                if (!skip) begin
                    if (a < sz)
                        req(2'b00, 16'(a), BADPW, 64'h0, 1'b0, "R3 protected byte");
                    else
                        req(2'b01, 16'(a), BADPW, 64'h0, 1'b1, "R2 free byte");
                    req(2'b00, 16'(a), RDPW, 64'h0, 1'b1, "R3 read key opens");
                end
            end
        end

        // R4 per-type keys
        do_reset();
        set_ctl(8'h07, "R4 setup");
        req(2'b00, 16'd10, WRPW, 64'h0, 1'b0, "R4 write key on read");
        req(2'b01, 16'd10, RDPW, 64'h0, 1'b0, "R4 read key on write");
        req(2'b00, 16'd10, RDPW, 64'h0, 1'b1, "R4 read granted");
        req(2'b01, 16'd10, WRPW, 64'h0, 1'b1, "R4 write granted");
        // R5 control register keys
        req(2'b00, CTLA, RDPW, 64'h0, 1'b1, "R5 ctl read");
        req(2'b00, CTLA, WRPW, 64'h0, 1'b0, "R5 ctl read wrong key");
        req(2'b01, CTLA, RDPW, 64'h2B, 1'b0, "R5 ctl write wrong key");
        check(ctl == 8'h07, "R5 ctl unchanged", {56'h0, ctl}, 64'h07);
        set_ctl(8'h2B, "R5 ctl loaded");
        // R9 gap
        req(2'b00, 16'd8192, RDPW, 64'h0, 1'b0, "R9 first gap address");
        req(2'b01, 16'hFFFE, WRPW, 64'h0, 1'b0, "R9 last gap address");

        // R6 hardware lock
        do_reset();
        set_ctl(8'h87, "R6 lock bit set");
        wp = 1'b1;
        req(2'b01, CTLA, WRPW, 64'h05, 1'b0, "R6 locked write");
        check(ctl == 8'h87, "R6 locked unchanged", {56'h0, ctl}, 64'h87);
        req(2'b00, CTLA, RDPW, 64'h0, 1'b1, "R6 read under lock");
        wp = 1'b0;
        set_ctl(8'h05, "R6 pin low allows");
        wp = 1'b1;
        set_ctl(8'h06, "R6 bit low allows");
        wp = 1'b0;

        // R10 key replacement
        do_reset();
        set_ctl(8'h07, "R10 setup");
        req(2'b10, 16'd0, RDPW, NEW_RD, 1'b0, "R10 read key cannot swap");
        req(2'b10, 16'd0, WRPW, NEW_RD, 1'b1, "R10 swap read key");
        req(2'b00, 16'd5, RDPW, 64'h0, 1'b0, "R10 old read key dead");
        req(2'b00, 16'd5, NEW_RD, 64'h0, 1'b1, "R10 new read key");
        req(2'b11, 16'd0, BADPW, NEW_WR, 1'b0, "R10 bad swap write key");
        req(2'b11, 16'd0, WRPW, NEW_WR, 1'b1, "R10 swap write key");
        req(2'b01, 16'd5, WRPW, 64'h0, 1'b0, "R10 old write key dead");
        req(2'b01, 16'd5, NEW_WR, 64'h0, 1'b1, "R10 new write key");

        // R7 tamper count
        do_reset();
        set_ctl(8'h01, "R7 setup");
        for (int i = 0; i < 7; i++)
            req(2'b00, 16'd0, BADPW, 64'h0, 1'b0, "R7 wrong key");
        req(2'b00, 16'd0, RDPW, 64'h0, 1'b1, "R7 count 7 still open");
        req(2'b00, 16'd0, BADPW, 64'h0, 1'b0, "R7 eighth wrong key");
        req(2'b00, 16'd0, RDPW, 64'h0, 1'b0, "R7 saturated refuses");
        req(2'b01, CTLA, WRPW, 64'h03, 1'b0, "R7 saturated ctl write");
        check(ctl == 8'h01, "R7 ctl kept", {56'h0, ctl}, 64'h01);
        req(2'b00, 16'd100, BADPW, 64'h0, 1'b1, "R7 free byte still open");
        do_reset();
        set_ctl(8'h01, "R7 reset clears count");
        req(2'b00, 16'd0, RDPW, 64'h0, 1'b1, "R7 reset reopens");

        // R8 low supply
        set_ctl(8'h41, "R8 flag set");
        @(negedge clk);
        low = 1'b1;
        req(2'b00, 16'd0, RDPW, 64'h0, 1'b0, "R8 read blocked");
        check(ctl == 8'h01, "R8 flag cleared", {56'h0, ctl}, 64'h01);
        req(2'b01, CTLA, WRPW, 64'h47, 1'b0, "R8 ctl write blocked");
        req(2'b01, 16'd500, BADPW, 64'h0, 1'b0, "R8 free byte blocked");
        check(ctl == 8'h01, "R8 ctl unchanged", {56'h0, ctl}, 64'h01);
        @(negedge clk);
        low = 1'b0;
        req(2'b00, 16'd0, RDPW, 64'h0, 1'b1, "R8 released");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule